// File: doc/BRIEF.md
# Cascaded Gated PWM Timer

The block holds a chain of identical up-counting PWM timers. Each stage has its own reload limit, compare threshold and repetition count, one PWM output and a trigger output. The trigger output is a one-clock pulse issued on the stage's update event, which is a counter wrap that has passed the repetition filter. Each stage runs either free as a master or as a gated slave. A gated slave advances only in cycles where its trigger input is high.

Stage 0 takes its trigger from a top-level pin. Every later stage takes the trigger output of the stage before it. A single master therefore drives a chain of slower PWM waveforms that stay locked to it. A slave's update rate is the master's update rate divided by (slave reload + 1). The master's own update rate is its wrap rate divided by (repetition + 1).

Software programs the stages through a write-only port that selects a stage and a register. The reload, compare and repetition values are buffered. They reach the running counter only at its next update, so a period is never cut short.

Top module: `pwm_cascade_top`

## Requirements
- R1: A running stage counts 0,1,…,RLD on each enabled cycle, then returns to 0. With repetition 0, trig_o pulses high for exactly one clock per wrap, so a stage issues one pulse every RLD+1 counting cycles.
- R2: pwm_o is high while the count is below CMP. This gives min(CMP,RLD+1) high cycles in every RLD+1. CMP=0 keeps the output low, CMP>RLD keeps it high, and a disabled stage drives it low.
- R3: Reload, compare and repetition writes made while a stage runs take effect only at its next update event. While the stage is disabled they take effect at once.
- R4: With repetition value N, a stage issues one update (trig_o pulse) every N+1 counter wraps.
- R5: A gated slave advances only in cycles where its trigger input is high. It holds its count otherwise, so a slave whose trigger stays low remains frozen.
- R6: A master stage ignores its trigger input.
- R7: Stage 0 is triggered by trig_i and stage k by trig_o[k-1]. With all repetitions at 0, a chain of equal reloads R gives update rates that each fall by a factor of R+1 per stage, and every stage keeps its own duty.
- R8: While tick_i is low no counter moves and no update is issued.
- R9: After reset every stage is disabled, and pwm_o and trig_o are all low.
- R10: Register map per stage, chosen by wr_sel_i: wr_addr_i 0 = reload, 1 = compare, 2 = repetition, 3 = control. In the control word, bit0 enables the stage and bit1 selects gated slave mode. Clearing bit0 returns the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counting clock enable shared by all stages |
| trig_i | input | 1 | Trigger input of stage 0 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | SEL_W | Stage select |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | CNT_W | Write data |
| pwm_o | output | N_STAGE | PWM output of each stage |
| trig_o | output | N_STAGE | Update pulse of each stage |

## Verification
Single-stage duty and update rate are tried over a table of reload/compare pairs. The table covers a typical quarter duty, compare zero, compare above the reload, compare equal to the reload, and reload zero. Together these separate a wrong comparison direction, an off-by-one wrap and a missing saturation. Cascade and repetition runs count pulses per stage over windows that are whole multiples of the slowest period. This tells a correct one-step-per-trigger gate apart from level gating or a misrouted chain. A mid-period reload change measures two consecutive period lengths, which exposes shadow registers that load too early. Gate-held-low, gate-dropped-mid-count and clock-enable-low runs confirm that the count freezes where it should.

// File: rtl/pwm_cascade_pkg.sv
package pwm_cascade_pkg;
  typedef enum logic [1:0] {
    REG_RLD  = 2'd0,
    REG_CMP  = 2'd1,
    REG_REP  = 2'd2,
    REG_CTRL = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic slave;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tmr_shadow.sv
module tmr_shadow
  import pwm_cascade_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             upd_i,
  output logic             en_o,
  output logic             slave_o,
  output logic [CNT_W-1:0] rld_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [REP_W-1:0] rep_o,
  output logic [REP_W-1:0] rep_pre_o
);
  logic [CNT_W-1:0] rld_pre, cmp_pre, rld_act, cmp_act;
  logic [REP_W-1:0] rep_pre, rep_act;
  ctrl_t            ctrl_q;
  logic             load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_pre <= '0;
      cmp_pre <= '0;
      rep_pre <= '0;
      ctrl_q  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        REG_RLD:  rld_pre <= data_i;
        REG_CMP:  cmp_pre <= data_i;
        REG_REP:  rep_pre <= data_i[REP_W-1:0];
        default:  ctrl_q  <= ctrl_t'(data_i[1:0]);
      endcase
    end
  end

  // idle stage tracks preload directly
  assign load = upd_i | ~ctrl_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_act <= '0;
      cmp_act <= '0;
      rep_act <= '0;
    end else if (load) begin
      rld_act <= rld_pre;
      cmp_act <= cmp_pre;
      rep_act <= rep_pre;
    end
  end

  assign en_o      = ctrl_q.en;
  assign slave_o   = ctrl_q.slave;
  assign rld_o     = rld_act;
  assign cmp_o     = cmp_act;
  assign rep_o     = rep_act;
  assign rep_pre_o = rep_pre;

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && !upd_i) |=> ($stable(rld_act) && $stable(cmp_act) && $stable(rep_act))); // R3
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             slave_i,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] rld_i,
  input  logic [REP_W-1:0] rep_act_i,
  input  logic [REP_W-1:0] rep_pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             trig_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [REP_W-1:0] rep_q;
  logic             run, wrap, upd, trg_q;

  assign run  = en_i & tick_i & (~slave_i | trig_i);
  assign wrap = run & (cnt_q >= rld_i);
  assign upd  = wrap & (rep_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rep_q <= '0;
      trg_q <= 1'b0;
    end else begin
      trg_q <= upd;
      if (!en_i) begin
        cnt_q <= '0;
        rep_q <= rep_pre_i;
      end else if (wrap) begin
        cnt_q <= '0;
        rep_q <= upd ? rep_pre_i : rep_q - REP_W'(1);
      end else if (run) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign upd_o  = upd;
  assign trig_o = trg_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= rld_i)); // R1
  AST_UPD_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trg_q |-> (cnt_q == '0)); // R1
  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && slave_i && !trig_i) |=> $stable(cnt_q)); // R5
  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> ($stable(cnt_q) && !trg_q)); // R8
  AST_REP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (rep_q <= rep_act_i)); // R4
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int CNT_W = 16
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             pwm_o
);
  // cnt never exceeds reload, so cmp > reload saturates high
  assign pwm_o = en_i & (cnt_i < cmp_i);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] data_i,
  output logic             pwm_o,
  output logic             trig_o
);
  logic             en, slave, upd;
  logic [CNT_W-1:0] rld, cmp, cnt;
  logic [REP_W-1:0] rep_act, rep_pre;

  tmr_shadow #(.CNT_W(CNT_W), .REP_W(REP_W)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .upd_i     (upd),
    .en_o      (en),
    .slave_o   (slave),
    .rld_o     (rld),
    .cmp_o     (cmp),
    .rep_o     (rep_act),
    .rep_pre_o (rep_pre)
  );

  tmr_count #(.CNT_W(CNT_W), .REP_W(REP_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .slave_i   (slave),
    .tick_i    (tick_i),
    .trig_i    (trig_i),
    .rld_i     (rld),
    .rep_act_i (rep_act),
    .rep_pre_i (rep_pre),
    .cnt_o     (cnt),
    .upd_o     (upd),
    .trig_o    (trig_o)
  );

  tmr_cmp #(.CNT_W(CNT_W)) u_cmp (
    .en_i  (en),
    .cnt_i (cnt),
    .cmp_i (cmp),
    .pwm_o (pwm_o)
  );
endmodule

// File: rtl/pwm_cascade_top.sv
module pwm_cascade_top #(
  parameter int N_STAGE = 3,
  parameter int CNT_W   = 16,
  parameter int REP_W   = 8,
  localparam int SEL_W  = (N_STAGE > 1) ? $clog2(N_STAGE) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               trig_i,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic [N_STAGE-1:0] pwm_o,
  output logic [N_STAGE-1:0] trig_o
);
  logic [N_STAGE-1:0] trg;

  for (genvar k = 0; k < N_STAGE; k++) begin : g_stage
    logic tin;
    logic wr;
    if (k == 0) begin : g_head
      assign tin = trig_i;
    end else begin : g_link
      assign tin = trg[k-1];
    end
    assign wr = wr_en_i & (wr_sel_i == SEL_W'(k));

    tmr_unit #(.CNT_W(CNT_W), .REP_W(REP_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .trig_i (tin),
      .wr_i   (wr),
      .addr_i (wr_addr_i),
      .data_i (wr_data_i),
      .pwm_o  (pwm_o[k]),
      .trig_o (trg[k])
    );
  end

  assign trig_o = trg;
endmodule

// File: tb/pwm_cascade_top_tb_top.sv
module pwm_cascade_top_tb_top;
  localparam int NS = 3;
  localparam int K  = 4;
  localparam int N_VEC = 6;
  localparam int V_RLD [N_VEC] = '{3, 7, 9, 4, 15, 0};
  localparam int V_CMP [N_VEC] = '{1, 2, 0, 9, 15, 1};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic trig_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [1:0] wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [NS-1:0] pwm_o, trig_o;

  int total = 0, bad = 0, cyc = 0;
  int hi_c [NS];
  int tr_c [NS];

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  pwm_cascade_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .trig_i(trig_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .pwm_o(pwm_o), .trig_o(trig_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int s, input int a, input int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 2'(s); wr_addr_i = 2'(a); wr_data_i = 16'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic setup(input int s, input int rld, input int cmp, input int rep);
    wr(s, 0, rld); wr(s, 1, cmp); wr(s, 2, rep);
  endtask

  task automatic stop_all();
    for (int s = 0; s < NS; s++) wr(s, 3, 0);
  endtask

  task automatic run_win(input int n);
    for (int s = 0; s < NS; s++) begin hi_c[s] = 0; tr_c[s] = 0; end
    repeat (n) begin
      @(negedge clk_i);
      for (int s = 0; s < NS; s++) begin
        if (pwm_o[s]) hi_c[s]++;
        if (trig_o[s]) tr_c[s]++;
      end
    end
  endtask

  task automatic wait_trig0();
    do @(negedge clk_i); while (!trig_o[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, c1, c2, t, e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 reset state
    run_win(10);
    chk("R9 pwm after reset", hi_c[0] + hi_c[1] + hi_c[2], 0);
    chk("R9 trig after reset", tr_c[0] + tr_c[1] + tr_c[2], 0);

    // R1 R2 R6 vector table, stage 0 master, trig_i held low
    for (int v = 0; v < N_VEC; v++) begin
      stop_all();
      setup(0, V_RLD[v], V_CMP[v], 0);
      wr(0, 3, 1);
      repeat (3) @(negedge clk_i);
      run_win(K * (V_RLD[v] + 1));
      e = (V_CMP[v] < V_RLD[v] + 1) ? V_CMP[v] : V_RLD[v] + 1;
      chk($sformatf("R2 duty vec%0d", v), hi_c[0], K * e);
      chk($sformatf("R1 R6 updates vec%0d", v), tr_c[0], K);
    end

    // R10 clearing enable drops output
    wr(0, 3, 0);
    run_win(5);
    chk("R10 R2 disabled low", hi_c[0], 0);

    // R7 three-stage cascade
    stop_all();
    for (int s = 0; s < NS; s++) setup(s, 3, 1, 0);
    wr(2, 3, 3); wr(1, 3, 3); wr(0, 3, 1);
    repeat (80) @(negedge clk_i);
    run_win(128);
    chk("R7 stage0 updates", tr_c[0], 32);
    chk("R7 stage1 updates", tr_c[1], 8);
    chk("R7 stage2 updates", tr_c[2], 2);
    chk("R7 stage0 duty", hi_c[0], 32);
    chk("R7 stage1 duty", hi_c[1], 32);
    chk("R7 stage2 duty", hi_c[2], 32);

    // R4 repetition
    stop_all();
    setup(0, 3, 1, 2);
    setup(1, 1, 1, 0);
    wr(1, 3, 3); wr(0, 3, 1);
    repeat (30) @(negedge clk_i);
    run_win(120);
    chk("R4 master updates", tr_c[0], 10);
    chk("R4 slave updates", tr_c[1], 5);
    chk("R4 slave duty", hi_c[1], 60);

    // R5 gated slave on stage 0
    stop_all();
    setup(0, 3, 2, 0);
    wr(0, 3, 3);
    run_win(50);
    chk("R5 frozen pwm high", hi_c[0], 50);
    chk("R5 frozen no update", tr_c[0], 0);
    @(negedge clk_i);
    trig_i = 1'b1;
    t = 0;
    repeat (6) begin
      @(negedge clk_i);
      if (trig_o[0]) t++;
    end
    trig_i = 1'b0;
    chk("R5 gated updates", t, 1);
    run_win(20);
    chk("R5 held count pwm", hi_c[0], 0);
    chk("R5 held no update", tr_c[0], 0);

    // R8 clock enable low
    stop_all();
    setup(0, 3, 2, 0);
    wr(0, 3, 1);
    repeat (5) @(negedge clk_i);
    tick_i = 1'b0;
    run_win(20);
    chk("R8 no update", tr_c[0], 0);
    chk("R8 pwm frozen", int'(hi_c[0] == 0 || hi_c[0] == 20), 1);
    tick_i = 1'b1;

    // R3 reload change mid-period
    stop_all();
    setup(0, 7, 4, 0);
    wr(0, 3, 1);
    wait_trig0();
    c0 = cyc;
    wr(0, 0, 3);
    wait_trig0();
    c1 = cyc;
    wait_trig0();
    c2 = cyc;
    chk("R3 old period kept", c1 - c0, 8);
    chk("R3 new period", c2 - c1, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule